// File: doc/BRIEF.md
# Dual-Register Uniform Word Generator

This block is a free-running pseudorandom source for streaming simulation engines and noise generators. On every clock cycle in which it is enabled it produces a new 32-bit word with a uniform distribution. The word is formed from two linear feedback shift registers of unequal length, 167 and 125 bits, and each register has its own XOR feedback.

Each output word mixes a slice of each register. The 32 most significant bits of the long register are XORed with the 32 least significant bits of the short register, and the short slice is bit-reversed first. Mixing two unrelated sequences this way hides the correlation between successive states of a single shift register.

The reset seed and the tap sets are fixed. A software model can therefore reproduce the output stream bit for bit.

Top module: `dual_lfsr_urng`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, `valid` is 0 and `dout` is 0. Reset loads every bit of both registers with 1.
- R2: The long register (167 bits, bit indices 166..0) advances by shifting left one place. Bit 0 receives the XOR of the bits at 1-based positions 167 and 161, which are indices 166 and 160.
- R3: The short register (125 bits, indices 124..0) advances the same way. Its new bit 0 is the XOR of 1-based positions 125, 124, 18 and 17, which are indices 124, 123, 17 and 16.
- R4: `dout` equals long[166:135] XOR rev(short[31:0]). Here rev places short bit 0 at `dout` bit 31 and short bit 31 at `dout` bit 0.
- R5: On a rising edge where `en` is 1, both registers advance once. On that same edge `dout` takes the word formed from the advanced contents and `valid` becomes 1, so the word is ready one cycle after `en` is sampled.
- R6: On an edge where `en` is 0, both registers and `dout` keep their values and `valid` becomes 0. The next enabled edge continues the sequence with no step skipped.
- R7: Neither register ever holds the all-zero state.
- R8: While `en` stays 1, a new word that matches the reference sequence appears on every cycle.
- R9: The first enabled edge after reset gives `dout` = 32'h8000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance both registers and emit one word |
| dout | output | 32 | Registered pseudorandom word |
| valid | output | 1 | High when `dout` holds a word produced on the previous edge |

## Verification
Each result is registered exactly once. After a rising edge on which `en` was sampled, both `dout` and `valid` are due in the same cycle, and after a stalled edge `valid` must drop in that cycle too. The bench drives `en` and `rst` at the falling edge and steps its reference model for the rising edge that follows. It then compares the outputs at the next falling edge, half a period after they change, so every comparison lands on the first cycle in which the new value is valid.

Checks on the long register's feedback taps are placed more than 135 enabled steps after reset. That is the first point at which those feedback bits can reach the output slice.

// File: rtl/urng_pkg.sv
package urng_pkg;
  // Register lengths and output word width
  localparam int LONG_LEN  = 167;
  localparam int SHORT_LEN = 125;
  localparam int WORD_W    = 32;

  // Feedback tap masks; a set bit marks a tap (indices are 1-based position minus one)
  localparam logic [LONG_LEN-1:0] LONG_TAPS =
    (LONG_LEN'(1) << 166) | (LONG_LEN'(1) << 160);
  localparam logic [SHORT_LEN-1:0] SHORT_TAPS =
    (SHORT_LEN'(1) << 124) | (SHORT_LEN'(1) << 123) |
    (SHORT_LEN'(1) << 17)  | (SHORT_LEN'(1) << 16);
endpackage

// File: rtl/fib_lfsr.sv
module fib_lfsr #(
  parameter int              WIDTH    = 16,
  parameter logic [WIDTH-1:0] TAP_MASK = WIDTH'(3) << (WIDTH - 2),
  parameter int              OUT_W    = 8,
  parameter bit              OUT_TOP  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] state,
  output logic [OUT_W-1:0] word_next
);
  logic             fb;
  logic [WIDTH-1:0] nxt;

  always_comb begin
    fb  = ^(state & TAP_MASK);
    nxt = {state[WIDTH-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (rst)     state <= '1;
    else if (en) state <= nxt;
  end

  // Slice of the advanced state offered to the word mixer
  generate
    if (OUT_TOP) begin : g_top
      assign word_next = nxt[WIDTH-1 -: OUT_W];
    end else begin : g_bottom
      assign word_next = nxt[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/word_mix.sv
module word_mix #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] hi_word,
  input  logic [W-1:0] lo_word,
  output logic [W-1:0] dout,
  output logic         valid
);
  logic [W-1:0] lo_rev;

  generate
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign lo_rev[i] = lo_word[W-1-i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= en;
      if (en) dout <= hi_word ^ lo_rev;
    end
  end
endmodule

// File: rtl/dual_lfsr_urng.sv
module dual_lfsr_urng #(
  parameter int                  A_LEN  = urng_pkg::LONG_LEN,
  parameter int                  B_LEN  = urng_pkg::SHORT_LEN,
  parameter int                  WORD_W = urng_pkg::WORD_W,
  parameter logic [A_LEN-1:0]    A_TAPS = urng_pkg::LONG_TAPS,
  parameter logic [B_LEN-1:0]    B_TAPS = urng_pkg::SHORT_TAPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [WORD_W-1:0] dout,
  output logic              valid
);
  logic [A_LEN-1:0]  a_state;
  logic [B_LEN-1:0]  b_state;
  logic [WORD_W-1:0] a_word;
  logic [WORD_W-1:0] b_word;

  fib_lfsr #(
    .WIDTH(A_LEN), .TAP_MASK(A_TAPS), .OUT_W(WORD_W), .OUT_TOP(1'b1)
  ) u_long (
    .clk(clk), .rst(rst), .en(en), .state(a_state), .word_next(a_word)
  );

  fib_lfsr #(
    .WIDTH(B_LEN), .TAP_MASK(B_TAPS), .OUT_W(WORD_W), .OUT_TOP(1'b0)
  ) u_short (
    .clk(clk), .rst(rst), .en(en), .state(b_state), .word_next(b_word)
  );

  word_mix #(.W(WORD_W)) u_mix (
    .clk(clk), .rst(rst), .en(en),
    .hi_word(a_word), .lo_word(b_word),
    .dout(dout), .valid(valid)
  );
endmodule

// File: rtl/dual_lfsr_urng_chk.sv
module dual_lfsr_urng_chk #(
  parameter int A_LEN  = 167,
  parameter int B_LEN  = 125,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [WORD_W-1:0] dout,
  input logic              valid,
  input logic [A_LEN-1:0]  a_state,
  input logic [B_LEN-1:0]  b_state
);
  function automatic logic [WORD_W-1:0] flip(input logic [WORD_W-1:0] v);
    for (int i = 0; i < WORD_W; i++) flip[i] = v[WORD_W-1-i];
  endfunction

  // R7
  long_nonzero_chk: assert property (@(posedge clk) disable iff (rst) a_state != '0);
  // R7
  short_nonzero_chk: assert property (@(posedge clk) disable iff (rst) b_state != '0);
  // R2
  long_shift_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> a_state[A_LEN-1:1] == $past(a_state[A_LEN-2:0]));
  // R3
  short_shift_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> b_state[B_LEN-1:1] == $past(b_state[B_LEN-2:0]));
  // R4
  word_form_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> dout == (a_state[A_LEN-1 -: WORD_W] ^ flip(b_state[WORD_W-1:0])));
  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst) en |=> valid);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid && $stable(dout) && $stable(a_state) && $stable(b_state));
endmodule

bind dual_lfsr_urng dual_lfsr_urng_chk #(
  .A_LEN(A_LEN), .B_LEN(B_LEN), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .dout(dout), .valid(valid),
  .a_state(a_state), .b_state(b_state)
);

// File: tb/dual_lfsr_urng_tb.sv
`timescale 1ns/1ps
module dual_lfsr_urng_tb;
  localparam int RAND_CYCLES = 12000;
  localparam int WD_CYCLES   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] dout;
  logic        valid;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Reference model state
  logic [166:0] ma;
  logic [124:0] mb;
  logic [31:0]  exp_dout;
  logic         exp_valid;
  int           steps;

  always #2 clk = ~clk;

  dual_lfsr_urng u_dut (.clk(clk), .rst(rst), .en(en), .dout(dout), .valid(valid));

  function automatic logic [31:0] rev32(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev32[i] = v[31-i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ma = '1; mb = '1; exp_dout = '0; exp_valid = 1'b0; steps = 0;
  endtask

  task automatic model_step();
    ma = {ma[165:0], ma[166] ^ ma[160]};
    mb = {mb[123:0], mb[124] ^ mb[123] ^ mb[17] ^ mb[16]};
    exp_dout  = ma[166:135] ^ rev32(mb[31:0]);
    exp_valid = 1'b1;
    steps++;
  endtask

  // Drive at falling edge, model the rising edge, compare at the next falling edge
  task automatic cycle(input logic r, input logic e, input string tag);
    rst = r; en = e;
    if (r) model_reset();
    else if (e) model_step();
    else exp_valid = 1'b0;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, valid}, {31'd0, exp_valid});
    check({tag, " dout"}, dout, exp_dout);
  endtask

  initial begin
    #(WD_CYCLES * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7265));
    model_reset();
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, "R1 reset");
    cycle(1'b0, 1'b0, "R1 after reset");
    // R9: first word after reset
    rst = 1'b0; en = 1'b1; model_step();
    @(negedge clk);
    check("R9 first word", dout, 32'h8000_0000);
    check("R5 valid after enable", {31'd0, valid}, 32'd1);
    // R3: short feedback reaches output immediately; R2 after 135 steps
    for (int i = 0; i < 100; i++) cycle(1'b0, 1'b1, "R3 R4 early");
    for (int i = 0; i < 150; i++) cycle(1'b0, 1'b1, "R2 R4 late");
    // R6: stall holds, resume continues
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, "R6 stall");
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, "R6 resume");
    // R8: constrained random enable pattern
    for (int i = 0; i < RAND_CYCLES; i++) begin
      automatic logic e = (($urandom % 4) != 0);
      cycle(1'b0, e, e ? "R8 run" : "R6 random stall");
    end
    // R1 reset while enabled, then R9 again
    for (int i = 0; i < 2; i++) cycle(1'b1, 1'b1, "R1 mid-run reset");
    cycle(1'b0, 1'b1, "R9 after mid-run reset");
    check("R9 restart word", dout, 32'h8000_0000);
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1, "R8 tail");
    // R7: reference state never reached zero and outputs agreed throughout
    check("R7 long nonzero", {31'd0, ma != '0}, 32'd1);
    check("R7 short nonzero", {31'd0, mb != '0}, 32'd1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule